// File: doc/BRIEF.md
# Posit Word Unpacker

This block turns one posit word (word size `N`, `WES` exponent-extension bits) into fixed-width floating-point fields that later arithmetic can consume without caring where the variable-length regime ended. It is purely combinational: a word applied at `word_i` produces its fields at the outputs in the same cycle, with no registers, no handshake and no rounding.

The signed significand is delivered in two's complement form, as a sign bit `S`, an implicit bit `I` and a fraction `F`. The decoded value is `(-2*S + I + F/2^FW) * 2^(exp_o - BIAS)`. Negative words are decoded directly, without first negating them. The regime's polarity is judged against the sign bit. The exponent-extension bits are inverted for negative words. Zero and the not-a-real pattern are flagged and given cleared fields.

The default configuration is `N=16`, `WES=1`. Any `N` from 8 to 32 with `WES <= N-4` is supported.

Top module: `posit_unpack`

## Requirements
- R1: The exponent output is `EW = $clog2(N)+1+WES` bits wide and the fraction output is `FW = N-3-WES` bits wide (6/12 at 16,1; 4/5 at 8,0; 6/3 at 8,2).
- R2: The all-zero word gives `nar_o=0`, `sign_o=0`, `implicit_o=0`, `exp_o=0`, `frac_o=0`.
- R3: The word with only the MSB set gives `nar_o=1`, `sign_o=1`, `implicit_o=0`, `exp_o=0`, `frac_o=0`, and no other word raises `nar_o`.
- R4: The regime is the run of identical bits starting just below the sign, ended by the opposite bit or by the word end. A run of length L whose bit differs from the sign has value L-1. A run whose bit equals the sign has value -L.
- R5: The `WES` bits after the regime terminator (missing bits read as 0) are inverted when the sign is 1, giving `e`. Then `exp_o = k*2^WES + e + 2^(EW-1)` modulo `2^EW`.
- R6: The bits after the exponent-extension bits are placed MSB-first in `frac_o`, and the missing low bits are filled with 0.
- R7: For every ordinary word, `implicit_o` is the inverse of `sign_o`, and the value formula above equals the posit's real value.
- R8: `exp_o` is nonzero for every word other than zero and not-a-real.
- R9: `sign_o` always equals the MSB of `word_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | N (16) | Posit word to unpack |
| nar_o | output | 1 | Word is the not-a-real pattern |
| sign_o | output | 1 | Sign bit, the MSB of the significand |
| implicit_o | output | 1 | Implicit significand bit |
| exp_o | output | EW (6) | Biased exponent, bias 2^(EW-1) |
| frac_o | output | FW (12) | Fraction, MSB-aligned |

## Verification
Since the block holds no state, a wrong run count, shift amount or polarity decision shows up at the outputs in the same cycle as the offending word. It appears as a shifted fraction, as an exponent off by one binade, or as an exponent off by a multiple of `2^WES`. Testing every default-size word against a real-valued model built from the posit definition exposes any such error. The eight-bit instances pin down the field widths and the case of zero exponent-extension bits.

// File: rtl/posit_unpack_pkg.sv
package posit_unpack_pkg;

  typedef enum logic [1:0] {
    WORD_ORDINARY = 2'd0,
    WORD_ZERO     = 2'd1,
    WORD_NAR      = 2'd2
  } word_kind_e;

  function automatic int exp_width(input int n, input int wes);
    return $clog2(n) + 1 + wes;
  endfunction

  function automatic int frac_width(input int n, input int wes);
    return n - 3 - wes;
  endfunction

endpackage

// File: rtl/posit_special_detect.sv
module posit_special_detect
  import posit_unpack_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] word_i,
  output word_kind_e   kind_o
);

  logic tail_any;

  always_comb begin
    tail_any = |word_i[N-2:0];
    if (tail_any)       kind_o = WORD_ORDINARY;
    else if (word_i[N-1]) kind_o = WORD_NAR;
    else                kind_o = WORD_ZERO;
  end

endmodule

// File: rtl/posit_run_counter.sv
module posit_run_counter #(
  parameter int W  = 15,
  parameter int CW = 4
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] run_len_o,
  output logic          lead_bit_o
);

  logic running;

  always_comb begin
    run_len_o  = '0;
    running    = 1'b1;
    lead_bit_o = vec_i[W-1];
    for (int i = W - 1; i >= 0; i--) begin
      if (running && (vec_i[i] == vec_i[W-1])) run_len_o = run_len_o + CW'(1);
      else running = 1'b0;
    end
  end

  // R4: the run is never empty, and it ends at a differing bit or at the word end
  always_comb begin
    assert_run_nonempty_R4: assert (run_len_o >= CW'(1) && int'(run_len_o) <= W);
    if (int'(run_len_o) < W)
      assert_run_terminated_R4: assert (vec_i[W - 1 - int'(run_len_o)] != lead_bit_o);
  end

endmodule

// File: rtl/posit_field_align.sv
module posit_field_align #(
  parameter int N   = 16,
  parameter int WES = 1,
  parameter int CW  = 4,
  localparam int ESW = (WES > 0) ? WES : 1,
  localparam int FW  = N - 3 - WES
) (
  input  logic [N-4:0]  body_i,
  input  logic [CW-1:0] run_len_i,
  output logic [ESW-1:0] es_o,
  output logic [FW-1:0] frac_o
);

  // The two bits below the sign always belong to the run or its terminator,
  // so the body starts after them and needs run_len-1 further positions.
  logic [N-4:0] aligned;

  always_comb aligned = body_i << (run_len_i - CW'(1));

  generate
    if (WES > 0) begin : g_es
      assign es_o = aligned[N-4 -: WES];
    end else begin : g_no_es
      assign es_o = 1'b0;
    end
  endgenerate

  assign frac_o = aligned[FW-1:0];

endmodule

// File: rtl/posit_exp_build.sv
module posit_exp_build #(
  parameter int N   = 16,
  parameter int WES = 1,
  parameter int CW  = 4,
  parameter int EW  = 6,
  localparam int ESW = (WES > 0) ? WES : 1,
  localparam logic [EW-1:0] BIAS = EW'(1) << (EW - 1)
) (
  input  logic           sign_i,
  input  logic           lead_bit_i,
  input  logic [CW-1:0]  run_len_i,
  input  logic [ESW-1:0] es_i,
  output logic [EW-1:0]  exp_o
);

  logic [EW-1:0] run_ext;
  logic [EW-1:0] regime;
  logic [EW-1:0] es_ext;
  logic          upward;

  always_comb begin
    run_ext = EW'(run_len_i);
    upward  = lead_bit_i ^ sign_i;
    regime  = upward ? (run_ext - EW'(1)) : (~run_ext + EW'(1));
  end

  generate
    if (WES > 0) begin : g_es
      assign es_ext = EW'(es_i ^ {WES{sign_i}});
    end else begin : g_no_es
      assign es_ext = '0;
    end
  endgenerate

  assign exp_o = (regime << WES) + es_ext + BIAS;

  // R4: the regime polarity decides which side of the bias the exponent lands on
  // R8: the biased exponent never reaches zero
  always_comb begin
    if (upward) assert_up_regime_R4: assert (exp_o >= BIAS);
    else        assert_down_regime_R4: assert (exp_o < BIAS);
    assert_exp_nonzero_R8: assert (exp_o != '0);
  end

endmodule

// File: rtl/posit_unpack.sv
module posit_unpack
  import posit_unpack_pkg::*;
#(
  parameter int N   = 16,
  parameter int WES = 1
) (
  input  logic [N-1:0] word_i,
  output logic         nar_o,
  output logic         sign_o,
  output logic         implicit_o,
  output logic [posit_unpack_pkg::exp_width(N, WES)-1:0]  exp_o,
  output logic [posit_unpack_pkg::frac_width(N, WES)-1:0] frac_o
);

  localparam int EW  = exp_width(N, WES);
  localparam int FW  = frac_width(N, WES);
  localparam int CW  = $clog2(N);
  localparam int ESW = (WES > 0) ? WES : 1;

  word_kind_e     kind;
  logic [CW-1:0]  run_len;
  logic           lead_bit;
  logic [ESW-1:0] es_bits;
  logic [FW-1:0]  frac_raw;
  logic [EW-1:0]  exp_raw;
  logic           ordinary;

  posit_special_detect #(.N(N)) u_special (
    .word_i (word_i),
    .kind_o (kind)
  );

  posit_run_counter #(.W(N - 1), .CW(CW)) u_run (
    .vec_i      (word_i[N-2:0]),
    .run_len_o  (run_len),
    .lead_bit_o (lead_bit)
  );

  posit_field_align #(.N(N), .WES(WES), .CW(CW)) u_align (
    .body_i    (word_i[N-4:0]),
    .run_len_i (run_len),
    .es_o      (es_bits),
    .frac_o    (frac_raw)
  );

  posit_exp_build #(.N(N), .WES(WES), .CW(CW), .EW(EW)) u_exp (
    .sign_i     (word_i[N-1]),
    .lead_bit_i (lead_bit),
    .run_len_i  (run_len),
    .es_i       (es_bits),
    .exp_o      (exp_raw)
  );

  always_comb begin
    ordinary   = (kind == WORD_ORDINARY);
    sign_o     = word_i[N-1];
    nar_o      = (kind == WORD_NAR);
    implicit_o = ordinary & ~word_i[N-1];
    exp_o      = ordinary ? exp_raw  : '0;
    frac_o     = ordinary ? frac_raw : '0;
  end

  // R2/R3: special words leave every numeric field cleared
  // R3: not-a-real is only ever flagged with the sign set
  // R8: ordinary words carry a nonzero exponent
  always_comb begin
    if (!ordinary)
      assert_special_clear_R2: assert (exp_o == '0 && frac_o == '0 && !implicit_o);
    if (nar_o)
      assert_nar_signed_R3: assert (sign_o && word_i[N-2:0] == '0);
    if (ordinary)
      assert_ordinary_exp_R8: assert (exp_o != '0);
  end

endmodule

// File: tb/tb_posit_unpack.sv
module tb_posit_unpack;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_compared = 0;
  int n_failed   = 0;
  bit finished   = 1'b0;

  // default 16,1 instance
  logic [15:0] w16;
  logic        nar16, sgn16, imp16;
  logic [5:0]  exp16;
  logic [11:0] frc16;

  posit_unpack dut (
    .word_i(w16), .nar_o(nar16), .sign_o(sgn16), .implicit_o(imp16),
    .exp_o(exp16), .frac_o(frc16)
  );

  // 8,0 instance
  logic [7:0] wa;
  logic       nara, sgna, impa;
  logic [3:0] expa;
  logic [4:0] frca;

  posit_unpack #(.N(8), .WES(0)) dut_p8e0 (
    .word_i(wa), .nar_o(nara), .sign_o(sgna), .implicit_o(impa),
    .exp_o(expa), .frac_o(frca)
  );

  // 8,2 instance
  logic [7:0] wb;
  logic       narb, sgnb, impb;
  logic [5:0] expb;
  logic [2:0] frcb;

  posit_unpack #(.N(8), .WES(2)) dut_p8e2 (
    .word_i(wb), .nar_o(narb), .sign_o(sgnb), .implicit_o(impb),
    .exp_o(expb), .frac_o(frcb)
  );

  task automatic check_eq(input string what, input longint act, input longint expv);
    n_compared++;
    if (act != expv) begin
      n_failed++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  function automatic real pow2(input int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  // Real value of an ordinary 16-bit, WES=1 posit, from the definition
  function automatic real ref_value(input logic [15:0] w);
    logic [15:0] m;
    int   phase, run, k, e, fpos;
    real  frac, v;
    logic first;
    m = w[15] ? (~w + 16'd1) : w;
    first = m[14];
    phase = 0; run = 0; e = 0; frac = 0.0; fpos = 1;
    for (int i = 14; i >= 0; i--) begin
      case (phase)
        0: if (m[i] == first) run++; else phase = 2;
        2: begin e = int'(m[i]); phase = 3; end
        default: begin
          if (m[i]) frac = frac + pow2(-fpos);
          fpos++;
        end
      endcase
    end
    k = first ? run - 1 : -run;
    v = (1.0 + frac) * pow2(k * 2 + e);
    return w[15] ? -v : v;
  endfunction

  task automatic apply16(input logic [15:0] w);
    @(posedge clk);
    w16 = w;
    @(negedge clk);
  endtask

  task automatic apply8(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    wa = a;
    wb = b;
    @(negedge clk);
  endtask

  task automatic expect16(input string tag, input logic [15:0] w, input logic s,
                          input logic i, input logic [5:0] e, input logic [11:0] f);
    apply16(w);
    check_eq($sformatf("%s sign w=%h", tag, w), sgn16, s);
    check_eq($sformatf("%s implicit w=%h", tag, w), imp16, i);
    check_eq($sformatf("%s exp w=%h", tag, w), exp16, e);
    check_eq($sformatf("%s frac w=%h", tag, w), frc16, f);
    check_eq($sformatf("%s nar w=%h", tag, w), nar16, 1'b0);
  endtask

  task automatic test_widths_r1();
    check_eq("R1 exp width 16,1", $bits(exp16), 6);
    check_eq("R1 frac width 16,1", $bits(frc16), 12);
    check_eq("R1 exp width 8,0", $bits(expa), 4);
    check_eq("R1 frac width 8,0", $bits(frca), 5);
    check_eq("R1 exp width 8,2", $bits(expb), 6);
    check_eq("R1 frac width 8,2", $bits(frcb), 3);
  endtask

  task automatic test_zero_r2();
    apply16(16'h0000);
    check_eq("R2 nar", nar16, 0);
    check_eq("R2 sign", sgn16, 0);
    check_eq("R2 implicit", imp16, 0);
    check_eq("R2 exp", exp16, 0);
    check_eq("R2 frac", frc16, 0);
  endtask

  task automatic test_nar_r3();
    apply16(16'h8000);
    check_eq("R3 nar", nar16, 1);
    check_eq("R3 sign", sgn16, 1);
    check_eq("R3 implicit", imp16, 0);
    check_eq("R3 exp", exp16, 0);
    check_eq("R3 frac", frc16, 0);
    apply8(8'h80, 8'h80);
    check_eq("R3 nar 8,0", nara, 1);
    check_eq("R3 nar 8,2", narb, 1);
  endtask

  // R4/R5/R6: directed field values at 16,1 (bias 32)
  task automatic test_fields_16();
    expect16("R4 one", 16'h4000, 0, 1, 6'd32, 12'h000);
    expect16("R6 long frac", 16'h4ABC, 0, 1, 6'd32, 12'hABC);
    expect16("R6 short frac", 16'h7A5F, 0, 1, 6'd39, 12'h2F8);
    expect16("R4 zero run", 16'h1234, 0, 1, 6'd28, 12'h468);
    expect16("R4 maxpos", 16'h7FFF, 0, 1, 6'd60, 12'h000);
    expect16("R4 minpos", 16'h0001, 0, 1, 6'd4, 12'h000);
    expect16("R5 minus one", 16'hC000, 1, 0, 6'd31, 12'h000);
    expect16("R5 minus 0.75", 16'hC800, 1, 0, 6'd31, 12'h800);
    expect16("R5 minus maxpos", 16'h8001, 1, 0, 6'd59, 12'h000);
    expect16("R5 minus minpos", 16'hFFFF, 1, 0, 6'd3, 12'h000);
  endtask

  // R4/R5/R6 at eight bits: 8,0 bias 8; 8,2 bias 32
  task automatic test_fields_8();
    apply8(8'b01010001, 8'b01011001);
    check_eq("R6 8,0 1.53125 frac", frca, 5'b10001);
    check_eq("R5 8,0 1.53125 exp", expa, 4'd8);
    check_eq("R5 8,2 nine exp", expb, 6'd35);
    check_eq("R6 8,2 nine frac", frcb, 3'b001);
    apply8(8'b01110001, 8'b01111111);
    check_eq("R4 8,0 4.5 exp", expa, 4'd10);
    check_eq("R6 8,0 4.5 frac", frca, 5'b00100);
    check_eq("R5 8,2 2^24 exp", expb, 6'd56);
    check_eq("R6 8,2 2^24 frac", frcb, 3'b000);
    apply8(8'b01111101, 8'b00000000);
    check_eq("R4 8,0 24 exp", expa, 4'd12);
    check_eq("R6 8,0 24 frac", frca, 5'b10000);
    check_eq("R2 8,2 zero exp", expb, 6'd0);
    apply8(8'b01111111, 8'b01000000);
    check_eq("R4 8,0 64 exp", expa, 4'd14);
    check_eq("R7 8,0 64 implicit", impa, 1);
    check_eq("R5 8,2 one exp", expb, 6'd32);
  endtask

  // R7/R8/R9 and R3 over every 16-bit word
  task automatic test_exhaustive_r7();
    for (int v = 0; v < 65536; v++) begin
      logic [15:0] w;
      real got, want, sig;
      w = 16'(v);
      apply16(w);
      check_eq($sformatf("R9 sign w=%h", w), sgn16, w[15]);
      if (w != 16'h0000 && w != 16'h8000) begin
        sig  = -2.0 * real'(sgn16) + real'(imp16) + real'(frc16) / 4096.0;
        got  = sig * pow2(int'(exp16) - 32);
        want = ref_value(w);
        n_compared++;
        if (got != want || imp16 == sgn16 || nar16 || exp16 == 6'd0) begin
          n_failed++;
          $display("FAIL R7/R8 w=%h actual=%g (i=%0d e=%0d f=%h nar=%0d) expected=%g",
                   w, got, imp16, exp16, frc16, nar16, want);
        end
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_failed);
      $finish;
    end
  endtask

  initial begin
    w16 = '0; wa = '0; wb = '0;
    repeat (2) @(posedge clk);
    test_widths_r1();
    test_zero_r2();
    test_nar_r3();
    test_fields_16();
    test_fields_8();
    test_exhaustive_r7();
    summary();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_compared++;
    n_failed++;
    $display("FAIL watchdog expired actual=%0d expected<%0d cycles", WATCHDOG_CYCLES, WATCHDOG_CYCLES);
    summary();
  end

endmodule